// File: doc/BRIEF.md
# Square-Wave Tone Generator with PWM Volume

This block turns one fast system clock (125 MHz in the target system) into a one-bit audio signal for a mono output stage that is followed by an external low-pass filter. A 24-bit half-period input gives the number of clock cycles between edges of an internal square wave. One full tone period is therefore twice that value. For example, 150000 gives roughly 417 Hz, and about 142045 gives 440 Hz. A half period of zero silences the tone.

The low half of the tone drives a steady 0. The high half is filled with a fast PWM carrier, so that the filtered level, and with it the loudness, depends on a one-bit volume select. The carrier is a free-running 2-bit phase counter. Volume 1 gives a 50% duty cycle and volume 0 gives 25%, at a carrier rate of a quarter of the clock. An enable input forces the output low. The final output comes from a register, so the pin never sees combinational glitches.

Top module: `sqtone_gen`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `audio_out` is 0. The tone state, the toggle count and the carrier phase all start at 0.
- R2: With a non-zero half period P held constant, the internal tone changes level once every P clock cycles. The first change follows the P-th rising edge after reset release.
- R3: While `half_period` is 0, the tone is forced low and the toggle count is held at 0, so `audio_out` stays 0.
- R4: When `tone_en` is 0 at a rising edge, `audio_out` is 0 after that edge.
- R5: While the tone is in its low half, `audio_out` is 0.
- R6: With `vol_hi` = 1 during the high half, `audio_out` is high in carrier phases 0 and 1 and low in phases 2 and 3 of every 4-cycle carrier frame (50% duty cycle).
- R7: With `vol_hi` = 0 during the high half, `audio_out` is high only in carrier phase 0 (25% duty cycle).
- R8: The carrier phase counts 0,1,2,3,0,… on every clock after reset, whatever the enable, volume or period inputs.
- R9: If the half period changes so that the current count is at or above the new value minus one, the count restarts at 0 on the next edge and the tone changes level there. There is no long wrap-around.
- R10: `audio_out` is registered. Its value after an edge equals enable AND tone AND carrier level as they stood before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tone_en | input | 1 | Output enable; 0 forces the output low |
| half_period | input | 24 | Clock cycles between tone edges; 0 mutes |
| vol_hi | input | 1 | Volume select: 1 gives 50% carrier duty, 0 gives 25% |
| audio_out | output | 1 | Registered PWM audio bit |

## Verification
The hardest state to reach from the ports is a half period that shrinks while the toggle count already sits at or above the new limit. Zero periods arriving in the middle of a high half are a close second. The stimulus reaches both by holding a long period for a random number of cycles and then switching to a much shorter value, or to zero. A cycle-accurate bench model follows the tone edges and the carrier phase across each change. Fixed-window high counts also check the two duty cycles against values worked out by hand.

// File: rtl/sqtone_pkg.sv
package sqtone_pkg;
  localparam int unsigned DEF_PERIOD_W = 24;
  localparam int unsigned DEF_PWM_W    = 2;

  typedef enum logic {
    TONE_LOW  = 1'b0,
    TONE_HIGH = 1'b1
  } tone_lvl_e;
endpackage

// File: rtl/sqtone_toggle_ctr.sv
module sqtone_toggle_ctr
  import sqtone_pkg::*;
#(
  parameter int unsigned PERIOD_W = DEF_PERIOD_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PERIOD_W-1:0] limit_i,
  output logic [PERIOD_W-1:0] count_o,
  output logic                tone_o
);
  localparam logic [PERIOD_W-1:0] ONE = PERIOD_W'(1);

  logic [PERIOD_W-1:0] cnt_q, cnt_d;
  tone_lvl_e           tone_q, tone_d;
  logic                muted;
  logic                at_limit;
  logic [PERIOD_W-1:0] last_idx;

  assign muted    = (limit_i == '0);
  assign last_idx = limit_i - ONE;
  assign at_limit = (cnt_q >= last_idx);

  always_comb begin
    cnt_d  = cnt_q;
    tone_d = tone_q;
    if (muted) begin
      cnt_d  = '0;
      tone_d = TONE_LOW;
    end else if (at_limit) begin
      cnt_d  = '0;
      tone_d = (tone_q == TONE_HIGH) ? TONE_LOW : TONE_HIGH;
    end else begin
      cnt_d  = cnt_q + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tone_q <= TONE_LOW;
    end else begin
      cnt_q  <= cnt_d;
      tone_q <= tone_d;
    end
  end

  assign count_o = cnt_q;
  assign tone_o  = (tone_q == TONE_HIGH);
endmodule

// File: rtl/sqtone_pwm_carrier.sv
module sqtone_pwm_carrier
  import sqtone_pkg::*;
#(
  parameter int unsigned PWM_W = DEF_PWM_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             loud_i,
  output logic [PWM_W-1:0] phase_o,
  output logic             level_o
);
  localparam int unsigned STEPS   = 1 << PWM_W;
  localparam int unsigned LOUD_HI = STEPS / 2;
  localparam int unsigned SOFT_HI = STEPS / 4;
  localparam logic [PWM_W:0] LOUD_LIM = (PWM_W+1)'(LOUD_HI);
  localparam logic [PWM_W:0] SOFT_LIM = (PWM_W+1)'(SOFT_HI);

  logic [PWM_W-1:0] phase_q, phase_d;
  logic [PWM_W:0]   phase_x;

  always_comb begin
    phase_d = phase_q + PWM_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  assign phase_x = {1'b0, phase_q};
  assign level_o = loud_i ? (phase_x < LOUD_LIM) : (phase_x < SOFT_LIM);
  assign phase_o = phase_q;
endmodule

// File: rtl/sqtone_out_stage.sv
module sqtone_out_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic tone_i,
  input  logic carrier_i,
  output logic out_o
);
  logic out_q, out_d;

  always_comb begin
    out_d = en_i & tone_i & carrier_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= 1'b0;
    else        out_q <= out_d;
  end

  assign out_o = out_q;
endmodule

// File: rtl/sqtone_gen.sv
module sqtone_gen
  import sqtone_pkg::*;
#(
  parameter int unsigned PERIOD_W = DEF_PERIOD_W,
  parameter int unsigned PWM_W    = DEF_PWM_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tone_en,
  input  logic [PERIOD_W-1:0] half_period,
  input  logic                vol_hi,
  output logic                audio_out
);
  logic [PERIOD_W-1:0] cnt_q;
  logic                tone_q;
  logic [PWM_W-1:0]    phase_q;
  logic                carrier;

  sqtone_toggle_ctr #(.PERIOD_W(PERIOD_W)) u_toggle (
    .clk     (clk),
    .rst_n   (rst_n),
    .limit_i (half_period),
    .count_o (cnt_q),
    .tone_o  (tone_q)
  );

  sqtone_pwm_carrier #(.PWM_W(PWM_W)) u_carrier (
    .clk     (clk),
    .rst_n   (rst_n),
    .loud_i  (vol_hi),
    .phase_o (phase_q),
    .level_o (carrier)
  );

  sqtone_out_stage u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (tone_en),
    .tone_i    (tone_q),
    .carrier_i (carrier),
    .out_o     (audio_out)
  );
endmodule

// File: rtl/sqtone_chk.sv
module sqtone_chk #(
  parameter int unsigned PERIOD_W = 24,
  parameter int unsigned PWM_W    = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                tone_en,
  input logic [PERIOD_W-1:0] half_period,
  input logic                vol_hi,
  input logic                audio_out,
  input logic                tone_q,
  input logic [PERIOD_W-1:0] cnt_q,
  input logic [PWM_W-1:0]    phase_q
);
  always_comb begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (!audio_out); // R1
    end
  end

  AST_TOGGLE_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (half_period != '0 && cnt_q >= half_period - PERIOD_W'(1)) |=> (tone_q != $past(tone_q))); // R2

  AST_MUTE_TONE: assert property (@(posedge clk) disable iff (!rst_n)
    (half_period == '0) |=> (!tone_q && cnt_q == '0)); // R3

  AST_EN_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !tone_en |=> !audio_out); // R4

  AST_LOW_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    !tone_q |=> !audio_out); // R5

  AST_SOFT_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
    (!vol_hi && phase_q != '0) |=> !audio_out); // R7

  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (phase_q == $past(phase_q) + PWM_W'(1))); // R8

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (half_period != '0) |=> (cnt_q < $past(half_period))); // R9
endmodule

bind sqtone_gen sqtone_chk #(.PERIOD_W(PERIOD_W), .PWM_W(PWM_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tone_en     (tone_en),
  .half_period (half_period),
  .vol_hi      (vol_hi),
  .audio_out   (audio_out),
  .tone_q      (tone_q),
  .cnt_q       (cnt_q),
  .phase_q     (phase_q)
);

// File: tb/tb_sqtone_gen.sv
`timescale 1ns/1ps
module tb_sqtone_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tone_en = 1'b0;
  logic [23:0] half_period = '0;
  logic        vol_hi = 1'b0;
  logic        audio_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  int m_cnt, m_tone, m_ph;

  always #4 clk = ~clk;

  sqtone_gen dut (
    .clk(clk), .rst_n(rst_n), .tone_en(tone_en),
    .half_period(half_period), .vol_hi(vol_hi), .audio_out(audio_out)
  );

  function automatic int carrier_lvl(int ph, bit loud);
    return loud ? int'(ph < 2) : int'(ph < 1);
  endfunction

  function automatic int expect_out(bit en, int tone, int ph, bit loud);
    return (en && tone == 1 && carrier_lvl(ph, loud) == 1) ? 1 : 0;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_cnt = 0; m_tone = 0; m_ph = 0;
  endtask

  // One clock: predict the output after the coming edge, advance the model, compare.
  task automatic step(string req);
    int exp;
    int p;
    exp = expect_out(tone_en, m_tone, m_ph, vol_hi);
    p = int'(half_period);
    if (p == 0) begin
      m_cnt = 0; m_tone = 0;
    end else if (m_cnt >= p - 1) begin
      m_cnt = 0; m_tone = 1 - m_tone;
    end else begin
      m_cnt++;
    end
    m_ph = (m_ph + 1) % 4;
    @(negedge clk);
    check(req, int'(audio_out), exp);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    model_reset();
    repeat (3) @(negedge clk);
    check("R1 during reset", int'(audio_out), 0);
    rst_n = 1'b1;
  endtask

  task automatic count_window(int n, output int highs);
    highs = 0;
    for (int i = 0; i < n; i++) begin
      step("R10 model");
      highs += int'(audio_out);
    end
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int highs;
    void'($urandom(32'd20240611));
    @(negedge clk);

    // R1 reset state, first cycle out of reset
    tone_en = 1'b1; vol_hi = 1'b1; half_period = 24'd16;
    do_reset();
    step("R1 first cycle");

    // R6 loud window: 64 cycles from reset with P=16 gives 16 highs
    do_reset();
    count_window(64, highs);
    check("R6 loud duty count", highs, 16);

    // R7 soft window: 8 highs
    vol_hi = 1'b0;
    do_reset();
    count_window(64, highs);
    check("R7 soft duty count", highs, 8);

    // R2 first edge after P cycles: P=8, loud; outputs 1..8 low, 9 high
    vol_hi = 1'b1; half_period = 24'd8;
    do_reset();
    for (int i = 0; i < 8; i++) step("R2 before first edge");
    check("R5 low half", int'(audio_out), 0);
    step("R2 first high");
    check("R2 first high level", int'(audio_out), 1);

    // R4 enable low forces zero
    tone_en = 1'b0;
    for (int i = 0; i < 20; i++) step("R4 disabled");
    tone_en = 1'b1;

    // R3 mute mid high half, then stays silent
    half_period = 24'd6;
    do_reset();
    for (int i = 0; i < 8; i++) step("R3 pre-mute");
    half_period = 24'd0;
    for (int i = 0; i < 40; i++) step("R3 muted");

    // R9 shrink while count is above the new limit
    half_period = 24'd40;
    do_reset();
    for (int i = 0; i < 25; i++) step("R9 long period");
    half_period = 24'd3;
    for (int i = 0; i < 30; i++) step("R9 after shrink");

    // R8/R10 random segments
    for (int s = 0; s < 300; s++) begin
      int len;
      int sel;
      sel = int'($urandom_range(0, 9));
      if (sel == 0)      half_period = 24'd0;
      else if (sel == 1) half_period = 24'(1);
      else if (sel == 2) half_period = 24'($urandom_range(30, 90));
      else               half_period = 24'($urandom_range(2, 20));
      tone_en = ($urandom_range(0, 5) != 0);
      vol_hi  = $urandom_range(0, 1) == 1;
      len = int'($urandom_range(3, 60));
      for (int i = 0; i < len; i++) step("R8 random");
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule